// File: doc/BRIEF.md
# Multi-Channel Triggered Snapshot Capture

This block records eight parallel sample streams into eight separate on-chip buffers, one per channel, and makes every buffer readable from a single Wishbone slave port. The samples arrive already aligned to one shared capture clock. The bus side runs on its own clock. Control bits move from the bus domain to the capture domain, and completion flags move back, through two-flop synchronizers.

A channel begins a capture in one of two ways. Software can set that channel's start bit. The other way is a rising edge on the shared trigger input while that channel's bit is set in the trigger mask. The channel stores one sample for each cycle in which its valid bit is high. It stops when its buffer is full and sets its finish flag. The flag stays set until the start condition is withdrawn, and only then can the channel start again. A finish flag can raise the interrupt output.

The sample inputs use valid only. The block never applies back-pressure, so no ready signal exists. A sample presented while its channel is not recording is dropped. Buffer depth is a parameter and must be a power of two. The full-size configuration holds 32768 samples per channel.

Top module: `multi_snap_capture`

## Requirements
- R1: After reset, wb_ack and irq are low, and the control, mask and status registers read as zero.
- R2: When the start bit for a channel is set (control register at byte offset 0x0, bit c for channel c), the channel fills its buffer with its valid samples. Samples go in arrival order starting at index 0, and cycles with valid low are skipped. When index DEPTH-1 has been written, the channel's finish bit is set (status register at offset 0x8, bit c, read-only).
- R3: A rising edge on trig_in starts only the channels whose bit is set in the mask register (offset 0x4, bit c). Channels whose mask bit is clear keep their finish bit low, and their buffer contents do not change.
- R4: Once a buffer is full, samples that arrive later do not change its contents.
- R5: A finish bit clears after the start condition is withdrawn. The start condition is withdrawn when software clears the start bit, or, for a channel armed by the trigger, when trig_in goes low or the channel's mask bit is cleared. The channel can then capture again.
- R6: When wb_adr[ADR_W-1] is 1, the bus reaches the buffer window. In that window, wb_adr[AW+1:2] selects the sample, wb_adr[AW+CW+1:AW+2] selects the channel, and wb_adr[1:0] is ignored. A read returns the stored SW-bit sample sign-extended to 32 bits.
- R7: A bus write into the buffer window stores wb_dat_i[SW-1:0] at the addressed slot, and a later read of that slot returns it sign-extended.
- R8: irq is high exactly when the interrupt-enable bit (control register bit 16) is set and at least one finish bit is set.
- R9: wb_ack is a single-cycle pulse. It rises one clock after a register access is presented and two clocks after a buffer read is presented.
- R10: The start bits, the interrupt-enable bit and the mask read back as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock shared by all sample streams |
| cap_rst_n | input | 1 | Active-low asynchronous reset, capture domain |
| smp_valid | input | NCH | Per-channel sample valid |
| smp_data | input | NCH*SW | Samples; channel c occupies bits [c*SW +: SW] |
| trig_in | input | 1 | Shared external trigger level |
| wb_clk | input | 1 | Bus clock |
| wb_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | ADR_W | Byte address |
| wb_dat_i | input | 32 | Bus write data |
| wb_dat_o | output | 32 | Bus read data |
| wb_ack | output | 1 | Bus acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the last slot of each buffer. A pointer that is off by one would wrap and overwrite index 0, or would set the finish flag early, and either fault breaks the run of consecutive sequence numbers that the bench checks. Samples are fed with regular gaps in valid, so a design that wrote during invalid cycles would store duplicate or junk values. The bench also targets channels left out of the trigger mask: their buffers are preloaded through debug writes, and a design that ignored the mask would overwrite them. Re-arming is checked by dropping and raising the trigger and the start bits. Channels 4 to 7 carry negative samples, so zero-extending on reads would show. The exact acknowledge latencies are measured and compared against the expected cycle counts.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [1:0] {CH_IDLE, CH_REC, CH_DONE} ch_state_e;
  typedef enum logic [1:0] {BS_IDLE, BS_RD, BS_WWAIT, BS_HOLD} bus_state_e;
  localparam int WORD_W = 32;
  localparam int IRQ_EN_BIT = 16;
endpackage

// File: rtl/snap_sync.sv
module snap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/snap_ram.sv
module snap_ram #(
  parameter  int DW    = 14,
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          rd_clk,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];
  always_ff @(posedge wr_clk) if (we) mem[wa] <= wd;
  always_ff @(posedge rd_clk) rq <= mem[ra];
endmodule

// File: rtl/snap_chan.sv
module snap_chan
  import snap_pkg::*;
#(
  parameter  int SW    = 14,
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          cap_clk,
  input  logic          rst_n,
  input  logic          start_s,
  input  logic          mask_s,
  input  logic          trig_s,
  input  logic          trig_rise,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_idx,
  input  logic [SW-1:0] dbg_data,
  input  logic          rd_clk,
  input  logic [AW-1:0] rd_idx,
  output logic [SW-1:0] rd_q,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  ch_state_e     st;
  logic [AW-1:0] ptr;
  logic          arm, go, cap_we;

  // trigger arming holds while the trigger level and mask bit stay high
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n)                arm <= 1'b0;
    else if (!trig_s || !mask_s) arm <= 1'b0;
    else if (trig_rise)        arm <= 1'b1;
  end

  assign go     = start_s | arm;
  assign cap_we = (st == CH_REC) && go && smp_valid;
  assign done   = (st == CH_DONE);

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= CH_IDLE;
      ptr <= '0;
    end else begin
      case (st)
        CH_IDLE: if (go) begin st <= CH_REC; ptr <= '0; end
        CH_REC: begin
          if (!go) st <= CH_IDLE;
          else if (smp_valid) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) st <= CH_DONE;
          end
        end
        CH_DONE: if (!go) st <= CH_IDLE;
        default: st <= CH_IDLE;
      endcase
    end
  end

  snap_ram #(.DW(SW), .DEPTH(DEPTH)) u_ram (
    .wr_clk(cap_clk),
    .we    (dbg_we | cap_we),
    .wa    (dbg_we ? dbg_idx : ptr),
    .wd    (dbg_we ? dbg_data : smp_data),
    .rd_clk(rd_clk),
    .ra    (rd_idx),
    .rq    (rd_q)
  );

  // R4
  full_stop_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (cap_we && ptr == LAST) |=> (st == CH_DONE));
  // R5
  rearm_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (st == CH_DONE && !go) |=> (st == CH_IDLE));
  // R3
  trig_mask_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
    $rose(arm) |-> $past(mask_s));
endmodule

// File: rtl/snap_bus.sv
module snap_bus
  import snap_pkg::*;
#(
  parameter  int NCH   = 8,
  parameter  int SW    = 14,
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(NCH),
  localparam int ADR_W = AW + CW + 3
) (
  input  logic              wb_clk,
  input  logic              wb_rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [ADR_W-1:0]  wb_adr,
  input  logic [WORD_W-1:0] wb_dat_i,
  output logic [WORD_W-1:0] wb_dat_o,
  output logic              wb_ack,
  output logic [NCH-1:0]    start,
  output logic [NCH-1:0]    mask,
  output logic              irq_en,
  input  logic [NCH-1:0]    finish,
  output logic [AW-1:0]     rd_idx,
  input  logic [NCH*SW-1:0] rd_q,
  output logic              req_tgl,
  input  logic              ack_tgl_s,
  output logic [CW-1:0]     dw_ch,
  output logic [AW-1:0]     dw_idx,
  output logic [SW-1:0]     dw_data
);
  bus_state_e        st;
  logic [CW-1:0]     a_ch, rd_ch;
  logic [SW-1:0]     sel_q;
  logic [WORD_W-1:0] reg_rd;
  logic              unused_bits;

  assign a_ch        = wb_adr[AW+2 +: CW];
  assign rd_idx      = wb_adr[2 +: AW];
  assign sel_q       = rd_q[rd_ch*SW +: SW];
  assign unused_bits = ^{wb_adr[1:0], wb_dat_i};

  always_comb begin
    reg_rd = '0;
    case (wb_adr[3:2])
      2'd0: begin reg_rd[NCH-1:0] = start; reg_rd[IRQ_EN_BIT] = irq_en; end
      2'd1: reg_rd[NCH-1:0] = mask;
      2'd2: reg_rd[NCH-1:0] = finish;
      default: ;
    endcase
  end

  always_ff @(posedge wb_clk or negedge wb_rst_n) begin
    if (!wb_rst_n) begin
      st <= BS_IDLE; wb_ack <= 1'b0; wb_dat_o <= '0;
      start <= '0; mask <= '0; irq_en <= 1'b0; rd_ch <= '0;
      req_tgl <= 1'b0; dw_ch <= '0; dw_idx <= '0; dw_data <= '0;
    end else begin
      wb_ack <= 1'b0;
      case (st)
        BS_IDLE: if (wb_cyc && wb_stb) begin
          if (!wb_adr[ADR_W-1]) begin
            wb_ack <= 1'b1; wb_dat_o <= reg_rd; st <= BS_HOLD;
            if (wb_we) begin
              case (wb_adr[3:2])
                2'd0: begin start <= wb_dat_i[NCH-1:0]; irq_en <= wb_dat_i[IRQ_EN_BIT]; end
                2'd1: mask <= wb_dat_i[NCH-1:0];
                default: ;
              endcase
            end
          end else if (!wb_we) begin
            rd_ch <= a_ch; st <= BS_RD;
          end else begin
            dw_ch <= a_ch; dw_idx <= rd_idx; dw_data <= wb_dat_i[SW-1:0];
            req_tgl <= ~req_tgl; st <= BS_WWAIT;
          end
        end
        BS_RD: begin
          wb_ack <= 1'b1; st <= BS_HOLD;
          wb_dat_o <= {{(WORD_W-SW){sel_q[SW-1]}}, sel_q};
        end
        BS_WWAIT: if (ack_tgl_s == req_tgl) begin
          wb_ack <= 1'b1; wb_dat_o <= '0; st <= BS_HOLD;
        end
        BS_HOLD: st <= BS_IDLE;
        default: st <= BS_IDLE;
      endcase
    end
  end

  // R9
  ack_pulse_chk: assert property (@(posedge wb_clk) disable iff (!wb_rst_n)
    wb_ack |=> !wb_ack);
  // R9
  rd_latency_chk: assert property (@(posedge wb_clk) disable iff (!wb_rst_n)
    (st == BS_RD) |=> wb_ack);
endmodule

// File: rtl/multi_snap_capture.sv
module multi_snap_capture
  import snap_pkg::*;
#(
  parameter  int NCH   = 8,
  parameter  int SW    = 14,
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(NCH),
  localparam int ADR_W = AW + CW + 3
) (
  input  logic              cap_clk,
  input  logic              cap_rst_n,
  input  logic [NCH-1:0]    smp_valid,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic              trig_in,
  input  logic              wb_clk,
  input  logic              wb_rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [ADR_W-1:0]  wb_adr,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack,
  output logic              irq
);
  logic [NCH-1:0]    start_w, mask_w, start_c, mask_c, done_c, done_w;
  logic              irq_en, req_tgl_w, req_s, req_d, trig_s, trig_d, ack_tgl_s;
  logic              dw_pulse, trig_rise;
  logic [CW-1:0]     dw_ch;
  logic [AW-1:0]     dw_idx, rd_idx;
  logic [SW-1:0]     dw_data;
  logic [NCH*SW-1:0] rd_q;

  snap_sync #(.W(2*NCH+2)) u_to_cap (
    .clk(cap_clk), .rst_n(cap_rst_n),
    .d({start_w, mask_w, trig_in, req_tgl_w}),
    .q({start_c, mask_c, trig_s, req_s}));

  snap_sync #(.W(NCH+1)) u_to_wb (
    .clk(wb_clk), .rst_n(wb_rst_n),
    .d({done_c, req_d}),
    .q({done_w, ack_tgl_s}));

  always_ff @(posedge cap_clk or negedge cap_rst_n) begin
    if (!cap_rst_n) begin
      trig_d <= 1'b0;
      req_d  <= 1'b0;
    end else begin
      trig_d <= trig_s;
      req_d  <= req_s;
    end
  end

  assign trig_rise = trig_s & ~trig_d;
  assign dw_pulse  = req_s ^ req_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    snap_chan #(.SW(SW), .DEPTH(DEPTH)) u_ch (
      .cap_clk  (cap_clk),
      .rst_n    (cap_rst_n),
      .start_s  (start_c[c]),
      .mask_s   (mask_c[c]),
      .trig_s   (trig_s),
      .trig_rise(trig_rise),
      .smp_valid(smp_valid[c]),
      .smp_data (smp_data[c*SW +: SW]),
      .dbg_we   (dw_pulse && (dw_ch == CW'(c))),
      .dbg_idx  (dw_idx),
      .dbg_data (dw_data),
      .rd_clk   (wb_clk),
      .rd_idx   (rd_idx),
      .rd_q     (rd_q[c*SW +: SW]),
      .done     (done_c[c]));
  end

  snap_bus #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) u_bus (
    .wb_clk(wb_clk), .wb_rst_n(wb_rst_n),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack),
    .start(start_w), .mask(mask_w), .irq_en(irq_en), .finish(done_w),
    .rd_idx(rd_idx), .rd_q(rd_q),
    .req_tgl(req_tgl_w), .ack_tgl_s(ack_tgl_s),
    .dw_ch(dw_ch), .dw_idx(dw_idx), .dw_data(dw_data));

  assign irq = irq_en & (|done_w);

  // R8
  irq_source_chk: assert property (@(posedge wb_clk) disable iff (!wb_rst_n)
    irq |-> (done_w != '0));
endmodule

// File: tb/multi_snap_capture_tb.sv
module multi_snap_capture_tb_top;
  localparam int NCH = 8, SW = 14, DEPTH = 16, ADR_W = 10;
  localparam logic [9:0] R_CTRL = 10'h000, R_MASK = 10'h004, R_STAT = 10'h008;

  logic cap_clk = 0, wb_clk = 0, cap_rst_n = 0, wb_rst_n = 0;
  logic [NCH-1:0] smp_valid = '0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic trig_in = 0, wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [ADR_W-1:0] wb_adr = '0;
  logic [31:0] wb_dat_i = '0, wb_dat_o;
  logic wb_ack, irq;

  int vectors = 0, miscompares = 0, cap_cyc = 0;
  int seq [NCH];
  logic [31:0] snap [NCH][DEPTH];
  logic [31:0] last_stat;
  bit done_flag = 0;

  always #2.5 wb_clk = ~wb_clk;
  always #4 cap_clk = ~cap_clk;

  multi_snap_capture #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) dut_i (.*);

  initial begin
    for (int c = 0; c < NCH; c++) seq[c] = 0;
    forever begin
      @(negedge cap_clk);
      cap_cyc++;
      for (int c = 0; c < NCH; c++) begin
        logic v;
        v = ((cap_cyc + c) % 4) != 0;
        smp_valid[c] = v;
        if (v) begin
          smp_data[c*SW +: SW] = {3'(c), 11'(seq[c])};
          seq[c]++;
        end else smp_data[c*SW +: SW] = 14'h1555;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [9:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int lat);
    @(negedge wb_clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = a; wb_dat_i = wd; lat = 0;
    do begin @(negedge wb_clk); lat++; end while (!wb_ack && lat < 1000);
    rd = wb_dat_o; wb_cyc = 0; wb_stb = 0; wb_we = 0;
  endtask

  function automatic logic [9:0] badr(input int c, input int i);
    return 10'((1 << 9) | (c << 6) | (i << 2));
  endfunction

  task automatic wait_status(input logic [7:0] want);
    logic [31:0] r; int l;
    for (int k = 0; k < 400; k++) begin
      xfer(0, R_STAT, 0, r, l);
      if (r[7:0] == want) break;
    end
    last_stat = r;
  endtask

  task automatic check_capture(input int c, input string tag);
    logic [31:0] r; int l;
    for (int i = 0; i < DEPTH; i++) begin
      xfer(0, badr(c, i), 0, r, l);
      snap[c][i] = r;
      check(r[31:14] == {18{r[13]}} && r[13:11] == 3'(c), tag, r, {{18{1'b0}}, 3'(c), 11'h0});
      if (i > 0)
        check(r[10:0] == 11'(snap[c][i-1][10:0] + 1), tag, r, snap[c][i-1] + 1);
    end
  endtask

  task automatic check_same(input int c, input string tag);
    logic [31:0] r; int l;
    for (int i = 0; i < DEPTH; i++) begin
      xfer(0, badr(c, i), 0, r, l);
      check(r == snap[c][i], tag, r, snap[c][i]);
    end
  endtask

  initial begin
    logic [31:0] r, e; int l;
    repeat (5) @(posedge wb_clk);
    cap_rst_n = 1; wb_rst_n = 1;
    @(negedge wb_clk);
    // R1 reset state
    check(wb_ack == 0, "R1 ack", 32'(wb_ack), 0);
    check(irq == 0, "R1 irq", 32'(irq), 0);
    xfer(0, R_STAT, 0, r, l); check(r == 0, "R1 status", r, 0);
    xfer(0, R_CTRL, 0, r, l); check(r == 0, "R1 ctrl", r, 0);
    xfer(0, R_MASK, 0, r, l); check(r == 0, "R1 mask", r, 0);
    // R9 latencies
    xfer(0, R_MASK, 0, r, l); check(l == 1, "R9 reg ack latency", 32'(l), 1);
    check(wb_ack == 1, "R9 ack high", 32'(wb_ack), 1);
    @(negedge wb_clk); check(wb_ack == 0, "R9 ack pulse", 32'(wb_ack), 0);
    xfer(0, badr(0, 3), 0, r, l); check(l == 2, "R9 buf ack latency", 32'(l), 2);
    @(negedge wb_clk); check(wb_ack == 0, "R9 ack pulse buf", 32'(wb_ack), 0);
    // R10 register read-back
    xfer(1, R_MASK, 32'hFFFF_FF5A, r, l);
    xfer(0, R_MASK, 0, r, l); check(r == 32'h5A, "R10 mask", r, 32'h5A);
    xfer(1, R_MASK, 0, r, l);
    xfer(1, R_CTRL, 32'h0001_0000, r, l);
    xfer(0, R_CTRL, 0, r, l); check(r == 32'h0001_0000, "R10 ctrl", r, 32'h0001_0000);
    // R7 debug writes with sign extension, R6 address bits [1:0] ignored
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1, badr(2, i), 32'hFFFF_0000 | 32'(14'h2000 | 14'(i * 5)), r, l);
      xfer(1, badr(5, i), 32'hABC0_0000 | 32'((i * 97) & 32'h1FFF), r, l);
    end
    for (int i = 0; i < DEPTH; i++) begin
      e = 32'hFFFF_E000 | 32'(i * 5);
      xfer(0, badr(2, i) | 10'(i % 4), 0, r, l); snap[2][i] = r;
      check(r == e, "R7 negative readback", r, e);
      e = 32'((i * 97) & 32'h1FFF);
      xfer(0, badr(5, i), 0, r, l); snap[5][i] = r;
      check(r == e, "R7 positive readback", r, e);
    end
    // R2 software start on channels 0,1
    xfer(1, R_CTRL, 32'h0001_0003, r, l);
    wait_status(8'h03);
    check(last_stat == 32'h03, "R2 finish bits", last_stat, 32'h03);
    check(irq == 1, "R8 irq on finish", 32'(irq), 1);
    check_capture(0, "R2 R6 ch0 data");
    check_capture(1, "R2 R6 ch1 data");
    repeat (60) @(posedge cap_clk);
    check_same(0, "R4 ch0 frozen");
    check_same(1, "R4 ch1 frozen");
    // R5 clearing start clears finish
    xfer(1, R_CTRL, 32'h0001_0000, r, l);
    wait_status(8'h00);
    check(last_stat == 0, "R5 finish cleared", last_stat, 0);
    @(negedge wb_clk); check(irq == 0, "R8 irq low", 32'(irq), 0);
    // R3 trigger with mask 0x49, irq disabled
    xfer(1, R_CTRL, 32'h0, r, l);
    xfer(1, R_MASK, 32'h49, r, l);
    repeat (6) @(posedge cap_clk);
    trig_in = 1;
    wait_status(8'h49);
    check(last_stat == 32'h49, "R3 masked finish", last_stat, 32'h49);
    @(negedge wb_clk); check(irq == 0, "R8 irq disabled", 32'(irq), 0);
    xfer(1, R_CTRL, 32'h0001_0000, r, l);
    check(irq == 1, "R8 irq enabled", 32'(irq), 1);
    check_capture(0, "R3 ch0 data");
    check_capture(3, "R3 ch3 data");
    check_capture(6, "R3 ch6 data");
    check_same(1, "R3 ch1 untouched");
    check_same(2, "R3 ch2 untouched");
    check_same(5, "R3 ch5 untouched");
    // R5 trigger drop then re-trigger
    trig_in = 0;
    wait_status(8'h00);
    check(last_stat == 0, "R5 trigger drop clears", last_stat, 0);
    repeat (6) @(posedge cap_clk);
    trig_in = 1;
    wait_status(8'h49);
    check(last_stat == 32'h49, "R5 re-trigger", last_stat, 32'h49);
    check_capture(3, "R5 ch3 recapture");
    // R5 mask removal releases a trigger-armed channel
    xfer(1, R_MASK, 32'h09, r, l);
    wait_status(8'h09);
    check(last_stat == 32'h09, "R5 mask drop clears", last_stat, 32'h09);
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wb_clk);
    if (!done_flag) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule